// File: doc/BRIEF.md
# Lockable configuration register bank

This block holds the small set of global configuration bits for a bus-attached I/O controller. Software reaches them through an index/data port: one index selects a register, a write strobe stores a data byte into it, and the read data always reflects the register currently selected. Two registers exist. The control register at index 0x21 carries a global device enable, a two-bit wait-state select and two sticky lock bits. The auxiliary register at index 0x22 is reserved and holds 0x63 after reset.

Both lock bits are write-one-to-set, and only reset clears them. The bank lock freezes both registers except the device-lock bit and the global enable. The device lock stops further changes to itself and drives an output that tells the downstream GPIO configuration registers to refuse writes.

The block has three outputs. The first is the global enable, taken straight from the register. The second is the wait-state select, decoded into a non-linear count and registered. The third is the GPIO lock, also registered.

Top module: `iocfg_lock_bank`

## Requirements
- R1: While rst_ni is low, and after it is released, index 0x21 reads 0x11 and index 0x22 reads 0x63. dev_en_o is 1, wait_cnt_o is 0 and gpio_lock_o is 0.
- R2: A write to 0x21 while the bank lock is clear stores data bits 3:2 (wait select) and bit 0 (global enable) on the clock edge where wr_en_i is high. The new value is visible on rdata_o right after that edge.
- R3: Bits 5:4 of 0x21 always read 01 and bit 1 always reads 0, whatever data is written.
- R4: Bit 7 of 0x21 (bank lock) is set by writing 1. Writing 0 leaves it unchanged, and only reset returns it to 0.
- R5: While the bank lock is set, writes leave bits 7 and 3:2 of 0x21 and all of 0x22 unchanged. Bit 6 and bit 0 of 0x21 stay writable.
- R6: Bit 6 of 0x21 (device lock) is set by writing 1. Writing 0 leaves it unchanged, and only reset clears it. gpio_lock_o goes high one clock edge after the bit is set.
- R7: wait_cnt_o gives the count for the wait select one clock edge after the select changes: 00 gives 0, 01 gives 2, 10 gives 6 and 11 gives 12.
- R8: dev_en_o always equals bit 0 of 0x21.
- R9: While the bank lock is clear, a write to 0x22 stores all eight bits, and they read back unchanged.
- R10: Reading any index other than 0x21 or 0x22 returns 0x00, and writing to such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the selected index |
| idx_i | input | 8 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected index |
| dev_en_o | output | 1 | Global device enable |
| wait_cnt_o | output | 4 | Decoded wait-state count |
| gpio_lock_o | output | 1 | Write lock for the GPIO configuration registers |

## Verification
The control register is written with every wait select and with both values of the enable. Writes with the reserved bits set to the wrong values show that those bits are fixed in hardware and not stored. Writes with 0 in a lock position are applied before and after the matching lock is set, which separates write-one-to-set behaviour from a plain stored bit. Once the bank lock is set, every field is written again, which shows exactly which bits the lock covers. A reset after both locks are set, followed by a fresh write, shows that reset is the only way to clear them. Separate directed writes check the one-edge delay on the registered outputs.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int unsigned IDX_W      = 8;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned WAIT_CNT_W = 4;
  localparam logic [IDX_W-1:0]  CTRL_IDX = 8'h21;
  localparam logic [IDX_W-1:0]  AUX_IDX  = 8'h22;
  localparam logic [DATA_W-1:0] CTRL_RST = 8'h11;
  localparam logic [DATA_W-1:0] AUX_RST  = 8'h63;

  // control register bit positions
  localparam int unsigned B_BANK_LOCK = 7;
  localparam int unsigned B_GPIO_LOCK = 6;
  localparam int unsigned B_WAIT_HI   = 3;
  localparam int unsigned B_WAIT_LO   = 2;
  localparam int unsigned B_GLOB_EN   = 0;

  function automatic logic [WAIT_CNT_W-1:0] wait_decode(input logic [1:0] sel);
    case (sel)
      2'b00:   return WAIT_CNT_W'(0);
      2'b01:   return WAIT_CNT_W'(2);
      2'b10:   return WAIT_CNT_W'(6);
      default: return WAIT_CNT_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfg_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = CTRL_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              bank_lock_o,
  output logic              gpio_lock_o,
  output logic [1:0]        wait_sel_o,
  output logic              glob_en_o
);
  logic       bank_lock_q, gpio_lock_q, glob_en_q;
  logic [1:0] wait_sel_q;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata_i[5:4], wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_lock_q <= RST_VAL[B_BANK_LOCK];
      gpio_lock_q <= RST_VAL[B_GPIO_LOCK];
      wait_sel_q  <= RST_VAL[B_WAIT_HI:B_WAIT_LO];
      glob_en_q   <= RST_VAL[B_GLOB_EN];
    end else if (we_i) begin
      // locks only ever set; bank lock guards itself and the wait field
      if (wdata_i[B_BANK_LOCK]) bank_lock_q <= 1'b1;
      if (wdata_i[B_GPIO_LOCK]) gpio_lock_q <= 1'b1;
      if (!bank_lock_q) wait_sel_q <= wdata_i[B_WAIT_HI:B_WAIT_LO];
      glob_en_q <= wdata_i[B_GLOB_EN];
    end
  end

  assign byte_o      = {bank_lock_q, gpio_lock_q, 2'b01, wait_sel_q, 1'b0, glob_en_q};
  assign bank_lock_o = bank_lock_q;
  assign gpio_lock_o = gpio_lock_q;
  assign wait_sel_o  = wait_sel_q;
  assign glob_en_o   = glob_en_q;
endmodule

// File: rtl/cfg_aux_reg.sv
module cfg_aux_reg
  import cfg_bank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = AUX_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= RST_VAL;
    else if (we_i && !lock_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_bank_pkg::*;
#(
  parameter logic [1:0] WAIT_RST = 2'b00
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            wait_sel_i,
  input  logic                  gpio_lock_i,
  output logic [WAIT_CNT_W-1:0] wait_cnt_o,
  output logic                  gpio_lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt_o  <= wait_decode(WAIT_RST);
      gpio_lock_o <= 1'b0;
    end else begin
      wait_cnt_o  <= wait_decode(wait_sel_i);
      gpio_lock_o <= gpio_lock_i;
    end
  end
endmodule

// File: rtl/iocfg_lock_bank.sv
module iocfg_lock_bank
  import cfg_bank_pkg::*;
#(
  parameter logic [IDX_W-1:0]  CTRL_AT   = CTRL_IDX,
  parameter logic [IDX_W-1:0]  AUX_AT    = AUX_IDX,
  parameter logic [DATA_W-1:0] CTRL_INIT = CTRL_RST,
  parameter logic [DATA_W-1:0] AUX_INIT  = AUX_RST
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  dev_en_o,
  output logic [WAIT_CNT_W-1:0] wait_cnt_o,
  output logic                  gpio_lock_o
);
  localparam logic [1:0] WAIT_INIT = CTRL_INIT[B_WAIT_HI:B_WAIT_LO];

  logic              ctrl_we, aux_we;
  logic [DATA_W-1:0] ctrl_byte, aux_byte;
  logic              bank_lock, gpio_lock_bit, glob_en;
  logic [1:0]        wait_sel;

  assign ctrl_we = wr_en_i && (idx_i == CTRL_AT);
  assign aux_we  = wr_en_i && (idx_i == AUX_AT);

  cfg_ctrl_reg #(.RST_VAL(CTRL_INIT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we),
    .wdata_i     (wdata_i),
    .byte_o      (ctrl_byte),
    .bank_lock_o (bank_lock),
    .gpio_lock_o (gpio_lock_bit),
    .wait_sel_o  (wait_sel),
    .glob_en_o   (glob_en)
  );

  cfg_aux_reg #(.RST_VAL(AUX_INIT)) u_aux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (aux_we),
    .lock_i  (bank_lock),
    .wdata_i (wdata_i),
    .q_o     (aux_byte)
  );

  cfg_out_stage #(.WAIT_RST(WAIT_INIT)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wait_sel_i  (wait_sel),
    .gpio_lock_i (gpio_lock_bit),
    .wait_cnt_o  (wait_cnt_o),
    .gpio_lock_o (gpio_lock_o)
  );

  always_comb begin
    if (idx_i == CTRL_AT)     rdata_o = ctrl_byte;
    else if (idx_i == AUX_AT) rdata_o = aux_byte;
    else                      rdata_o = '0;
  end

  assign dev_en_o = glob_en;
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [IDX_W-1:0]      idx_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic                  dev_en_o,
  input logic [WAIT_CNT_W-1:0] wait_cnt_o,
  input logic                  gpio_lock_o,
  input logic [DATA_W-1:0]     ctrl_byte,
  input logic [DATA_W-1:0]     aux_byte
);
  assert_bank_lock_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_byte[B_BANK_LOCK] |=> ctrl_byte[B_BANK_LOCK]);

  assert_gpio_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_byte[B_GPIO_LOCK] |=> ctrl_byte[B_GPIO_LOCK]);

  assert_gpio_lock_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_byte[B_GPIO_LOCK] |=> gpio_lock_o);

  assert_locked_wait_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_byte[B_BANK_LOCK] && wr_en_i && idx_i == CTRL_IDX)
      |=> $stable(ctrl_byte[B_WAIT_HI:B_WAIT_LO]));

  assert_locked_aux_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_byte[B_BANK_LOCK] && wr_en_i && idx_i == AUX_IDX) |=> $stable(aux_byte));

  assert_reserved_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == CTRL_IDX) |-> (rdata_o[5:4] == 2'b01 && !rdata_o[1]));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i != CTRL_IDX && idx_i != AUX_IDX) |-> rdata_o == '0);

  assert_wait_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt_o inside {4'd0, 4'd2, 4'd6, 4'd12});

  assert_dev_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == CTRL_IDX) |-> dev_en_o == rdata_o[B_GLOB_EN]);
endmodule

bind iocfg_lock_bank cfg_bank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .idx_i       (idx_i),
  .rdata_o     (rdata_o),
  .dev_en_o    (dev_en_o),
  .wait_cnt_o  (wait_cnt_o),
  .gpio_lock_o (gpio_lock_o),
  .ctrl_byte   (ctrl_byte),
  .aux_byte    (aux_byte)
);

// File: tb/sim_iocfg_lock_bank.sv
module sim_iocfg_lock_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 15;

  typedef struct packed {
    logic       wr;
    logic [7:0] widx;
    logic [7:0] wdata;
    logic [7:0] ridx;
    logic [7:0] exp_rd;
    logic       exp_dev;
    logic [3:0] exp_wait;
    logic       exp_gl;
    logic [3:0] req;
  } vec_t;

  // wr, widx, wdata, ridx, exp_rd, dev, wait, gpio_lock, requirement
  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 8'h21, 8'h05, 8'h21, 8'h15, 1'b1, 4'd2,  1'b0, 4'd2},  // R2 R7 sel 01
    '{1'b1, 8'h21, 8'h08, 8'h21, 8'h18, 1'b0, 4'd6,  1'b0, 4'd8},  // R8 R7 sel 10, enable off
    '{1'b1, 8'h21, 8'h3E, 8'h21, 8'h1C, 1'b0, 4'd12, 1'b0, 4'd3},  // R3 reserved bits written wrong
    '{1'b1, 8'h21, 8'h01, 8'h21, 8'h11, 1'b1, 4'd0,  1'b0, 4'd7},  // R7 sel 00
    '{1'b1, 8'h22, 8'hA5, 8'h22, 8'hA5, 1'b1, 4'd0,  1'b0, 4'd9},  // R9
    '{1'b1, 8'h22, 8'h63, 8'h22, 8'h63, 1'b1, 4'd0,  1'b0, 4'd9},  // R9
    '{1'b1, 8'h40, 8'hFF, 8'h40, 8'h00, 1'b1, 4'd0,  1'b0, 4'd10}, // R10 unmapped
    '{1'b0, 8'h00, 8'h00, 8'h21, 8'h11, 1'b1, 4'd0,  1'b0, 4'd10}, // R10 nothing changed
    '{1'b1, 8'h21, 8'h45, 8'h21, 8'h55, 1'b1, 4'd2,  1'b1, 4'd6},  // R6 set device lock
    '{1'b1, 8'h21, 8'h05, 8'h21, 8'h55, 1'b1, 4'd2,  1'b1, 4'd6},  // R6 zero does not clear
    '{1'b1, 8'h21, 8'h85, 8'h21, 8'hD5, 1'b1, 4'd2,  1'b1, 4'd4},  // R4 set bank lock
    '{1'b1, 8'h21, 8'h09, 8'h21, 8'hD5, 1'b1, 4'd2,  1'b1, 4'd4},  // R4 R5 lock and wait frozen
    '{1'b1, 8'h21, 8'h08, 8'h21, 8'hD4, 1'b0, 4'd2,  1'b1, 4'd5},  // R5 enable still writable
    '{1'b1, 8'h22, 8'h00, 8'h22, 8'h63, 1'b0, 4'd2,  1'b1, 4'd5},  // R5 aux frozen
    '{1'b1, 8'h21, 8'h01, 8'h21, 8'hD5, 1'b1, 4'd2,  1'b1, 4'd5}   // R5 enable back on
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] idx_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       dev_en_o;
  logic [3:0] wait_cnt_o;
  logic       gpio_lock_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  iocfg_lock_bank u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .idx_i       (idx_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .dev_en_o    (dev_en_o),
    .wait_cnt_o  (wait_cnt_o),
    .gpio_lock_o (gpio_lock_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_reset_state(input string req);
    idx_i = 8'h21;
    #1;
    check(req, "ctrl read", int'(rdata_o), 'h11);
    check(req, "dev_en", int'(dev_en_o), 1);
    check(req, "wait_cnt", int'(wait_cnt_o), 0);
    check(req, "gpio_lock", int'(gpio_lock_o), 0);
    idx_i = 8'h22;
    #1;
    check(req, "aux read", int'(rdata_o), 'h63);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 during reset
    @(negedge clk_i);
    check_reset_state("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state("R1");

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk_i);
      wr_en_i = VECS[i].wr;
      idx_i   = VECS[i].widx;
      wdata_i = VECS[i].wdata;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      idx_i   = VECS[i].ridx;
      @(negedge clk_i);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "rdata", int'(rdata_o), int'(VECS[i].exp_rd));
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "dev_en", int'(dev_en_o), int'(VECS[i].exp_dev));
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "wait_cnt", int'(wait_cnt_o), int'(VECS[i].exp_wait));
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "gpio_lock", int'(gpio_lock_o), int'(VECS[i].exp_gl));
    end

    // R4 R6: both locks set, only reset clears them
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_reset_state("R4");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state("R1");

    // R2 writable again after reset; R6 R7 output latency
    @(negedge clk_i);
    wr_en_i = 1'b1;
    idx_i   = 8'h21;
    wdata_i = 8'h4D;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    check("R2", "ctrl right after write", int'(rdata_o), 'h5D);
    check("R8", "dev_en right after write", int'(dev_en_o), 1);
    check("R6", "gpio_lock one edge early", int'(gpio_lock_o), 0);
    check("R7", "wait_cnt one edge early", int'(wait_cnt_o), 0);
    @(negedge clk_i);
    check("R6", "gpio_lock after delay", int'(gpio_lock_o), 1);
    check("R7", "wait_cnt after delay", int'(wait_cnt_o), 12);

    finish_run();
  end
endmodule